// File: doc/BRIEF.md
# Four-Input Sensed Interrupt Controller

This block turns four asynchronous input lines into interrupt requests. Each line has its own two-bit sense setting, which selects one of four detection rules: request while low, any change, falling transition, or rising transition. Each line first passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the one kept from the cycle before.

Edge-type events set a sticky per-line flag, and software clears that flag by writing a one to its bit. The low-level rule sets no flag. Its request follows the synchronized line directly, so the request ends as soon as the line returns high. A per-line enable mask and a global enable gate every request. The block presents one request bit per line and a single combined request. Because detection depends only on the line value, a driver that toggles its own line can raise a software interrupt.

Software reaches the sense settings, the mask and the flags through a small synchronous write port and a combinational read port.

Top module: `xirq_ctrl`

## Requirements
- R1: After synchronous reset, all of the following read as zero and are driven to zero: the sense register, the mask register, the flags, `irq_vec` and `irq_any`.
- R2: Register map, selected by `reg_addr`:
  - 0 selects the sense register. Line n uses bits [2n+1:2n], and the register is read/write.
  - 1 selects the mask register. Bits [3:0] are read/write, and bits [7:4] always read zero.
  - 2 selects the flag register. It reads the four flags in bits [3:0].
  - 3 reads zero.
- R3: The sense code 00 is the low-level rule. Request bit n is high while the synchronized line n is low, and it goes high two clock edges after the input goes low. It drops two edges after the input goes high.
- R4: The sense code 01 is the any-change rule. Any change of line n sets flag n.
- R5: The sense code 10 is the falling rule. Only a high-to-low change of line n sets flag n.
- R6: The sense code 11 is the rising rule. Only a low-to-high change of line n sets flag n.
- R7: Writing the flag register clears each flag whose data bit is one, and zero bits leave their flags unchanged. If a flag is being set in the same cycle as it is cleared, the set wins.
- R8: `irq_vec[n]` is high only when `mask[n]` and `gie` are both high. Its source is the flag of line n in the edge rules and the low line in the level rule. Flags still latch while the line is masked.
- R9: `irq_any` is the OR of `irq_vec`.
- R10: A write that changes line n's sense field blocks edge detection for line n in that cycle. The level rule never sets a flag.
- R11: In an edge rule, flag n becomes visible three clock edges after the input changes, and is not yet set after two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gie | input | 1 | Global interrupt enable |
| pin_in | input | 4 | Asynchronous interrupt lines |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq_vec | output | 4 | Per-line gated requests |
| irq_any | output | 1 | Combined request |

## Verification
The assertions check the following on every cycle:
- No request is raised without its mask bit and `gie`.
- The combined line is never high without a per-line request.
- A flag rises only after an edge rule was in force.
- A write-one clear takes effect when no event competes with it.
- A sense change keeps a clear flag clear.
- The level rule drops the request while the line is high.

The decode of each rule for each line and transition direction, the exact three-edge flag latency, the priority of set over clear and the register read-back can only be shown by the bench's timed scenarios. The bench sweeps every line, every rule and both directions.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned SENSE_W = 2;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        ADR_SENSE = 2'd0,
        ADR_MASK  = 2'd1,
        ADR_FLAG  = 2'd2,
        ADR_NONE  = 2'd3
    } addr_e;

    typedef struct packed {
        logic   wr;
        addr_e  addr;
    } bus_cmd_t;

    function automatic logic edge_hit(sense_e mode, logic cur, logic prev);
        case (mode)
            SNS_ANY:  return cur ^ prev;
            SNS_FALL: return prev & ~cur;
            SNS_RISE: return cur & ~prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int unsigned NPIN = 4,
    parameter int unsigned DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_cmd_t                cmd,
    input  logic [DW-1:0]           wdata,
    input  logic [NPIN-1:0]         flags,
    output logic [DW-1:0]           rdata,
    output logic [SENSE_W*NPIN-1:0] sense_q,
    output logic [NPIN-1:0]         mask_q,
    output logic [NPIN-1:0]         resync,
    output logic [NPIN-1:0]         clr
);

    localparam int unsigned SW = SENSE_W * NPIN;

    logic wr_sense, wr_mask, wr_flag;

    assign wr_sense = cmd.wr && (cmd.addr == ADR_SENSE);
    assign wr_mask  = cmd.wr && (cmd.addr == ADR_MASK);
    assign wr_flag  = cmd.wr && (cmd.addr == ADR_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else begin
            if (wr_sense) sense_q <= wdata[SW-1:0];
            if (wr_mask)  mask_q  <= wdata[NPIN-1:0];
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_ctl
        assign resync[i] = wr_sense &&
            (wdata[SENSE_W*i +: SENSE_W] != sense_q[SENSE_W*i +: SENSE_W]);
        assign clr[i] = wr_flag && wdata[i];
    end

    always_comb begin
        rdata = '0;
        case (cmd.addr)
            ADR_SENSE: rdata = DW'(sense_q);
            ADR_MASK:  rdata = DW'(mask_q);
            ADR_FLAG:  rdata = DW'(flags);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/xirq_pin.sv
module xirq_pin
    import xirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e mode,
    input  logic   cur,
    input  logic   resync,
    input  logic   clr,
    input  logic   en,
    output logic   flag,
    output logic   req
);

    logic prev_q;
    logic flag_q;
    logic evt;

    assign evt = !resync && edge_hit(mode, cur, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_q <= cur;
            if (evt)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign req  = en && ((mode == SNS_LOW) ? !cur : flag_q);

    // R4, R10: a flag can only rise after an edge rule was selected
    a_r4_flag_needs_edge_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(mode) != SNS_LOW));

    // R7: a clear with no competing event empties the flag
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !flag_q);

    // R10: a sense change keeps a clear flag clear
    a_r10_resync_blocks: assert property (@(posedge clk) disable iff (rst)
        (resync && !flag_q) |=> !flag_q);

    // R3: level rule releases the request while the line is high
    a_r3_level_release: assert property (@(posedge clk) disable iff (rst)
        (mode == SNS_LOW && cur) |-> !req);

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned NPIN        = 4,
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gie,
    input  logic [NPIN-1:0] pin_in,
    input  logic [1:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic [NPIN-1:0] irq_vec,
    output logic            irq_any
);

    localparam int unsigned SW = SENSE_W * NPIN;

    logic [NPIN-1:0] pin_s;
    logic [SW-1:0]   sense_q;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] resync;
    logic [NPIN-1:0] clr;
    logic [NPIN-1:0] flags;
    bus_cmd_t        cmd;

    assign cmd.wr   = reg_wr;
    assign cmd.addr = addr_e'(reg_addr);

    xirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    xirq_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (reg_wdata),
        .flags   (flags),
        .rdata   (reg_rdata),
        .sense_q (sense_q),
        .mask_q  (mask_q),
        .resync  (resync),
        .clr     (clr)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        xirq_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .mode   (sense_e'(sense_q[SENSE_W*i +: SENSE_W])),
            .cur    (pin_s[i]),
            .resync (resync[i]),
            .clr    (clr[i]),
            .en     (mask_q[i] && gie),
            .flag   (flags[i]),
            .req    (irq_vec[i])
        );
    end

    assign irq_any = |irq_vec;

    // R8: no request may pass a cleared mask bit
    a_r8_mask_gate: assert property (@(posedge clk) disable iff (rst)
        (irq_vec & ~mask_q) == '0);

    // R8: global enable low silences every request
    a_r8_gie_gate: assert property (@(posedge clk) disable iff (rst)
        !gie |-> (irq_vec == '0));

    // R9: combined line needs a per-line request
    a_r9_any_needs_vec: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> (irq_vec != '0));

endmodule

// File: tb/xirq_ctrl_tb_top.sv
module xirq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gie = 1'b0;
    logic [3:0] pin_in = 4'hF;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] irq_vec;
    logic       irq_any;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xirq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .gie       (gie),
        .pin_in    (pin_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_vec   (irq_vec),
        .irq_any   (irq_any)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic settle(input logic [3:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 sense", v, 8'h00);
        rd(2'd1, v); chk("R1 mask", v, 8'h00);
        rd(2'd2, v); chk("R1 flags", v, 8'h00);
        chk("R1 irq_vec", irq_vec, 4'h0);
        chk("R1 irq_any", irq_any, 1'b0);

        // R2 register map
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 mask reserved", v, 8'h0F);
        wr(2'd0, 8'hA5); rd(2'd0, v); chk("R2 sense rw", v, 8'hA5);
        rd(2'd3, v); chk("R2 unused addr", v, 8'h00);
        wr(2'd0, 8'h00);
        gie = 1'b1;

        // R3..R6, R9, R10, R11 sweep over lines, rules and directions
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [3:0] p;
                    logic lvl_new, exp_flag, exp_req;
                    p = 4'hF;
                    if (dir == 1) p[n] = 1'b0;
                    settle(p);
                    wr(2'd0, 8'(m << (2 * n)));
                    wr(2'd2, 8'h0F);
                    lvl_new = (dir == 1);
                    exp_flag = (m == 1) || (m == 2 && dir == 0) || (m == 3 && dir == 1);
                    pin_in[n] = lvl_new;
                    @(negedge clk);
                    @(negedge clk);
                    // two edges: level request tracks, edge flag not yet set (R3, R11)
                    exp_req = (m == 0) && !lvl_new;
                    chk("R3 level timing", irq_vec[n], exp_req);
                    rd(2'd2, v); chk("R11 flag not yet", v[n], 1'b0);
                    @(negedge clk);
                    rd(2'd2, v);
                    chk(m == 0 ? "R10 level no flag" : (m == 1 ? "R4 any change" :
                        (m == 2 ? "R5 falling" : "R6 rising")), v, 8'(exp_flag) << n);
                    exp_req = (m == 0) ? !lvl_new : exp_flag;
                    chk("R8 vec", irq_vec, 4'(exp_req) << n);
                    chk("R9 any", irq_any, exp_req);
                end
            end
        end

        // R8 masked latching and gating
        settle(4'hF);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h0F);
        pin_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd2, v); chk("R8 flag latches while masked", v, 8'h01);
        chk("R8 masked vec", irq_vec, 4'h0);
        wr(2'd1, 8'h01);
        chk("R8 unmasked vec", irq_vec, 4'h1);
        gie = 1'b0; #1;
        chk("R8 gie off vec", irq_vec, 4'h0);
        chk("R9 gie off any", irq_any, 1'b0);
        gie = 1'b1; #1;
        chk("R9 any on", irq_any, 1'b1);

        // R7 zero bits leave flags, one bit clears
        wr(2'd2, 8'h0E); rd(2'd2, v); chk("R7 zero no effect", v, 8'h01);
        wr(2'd2, 8'h01); rd(2'd2, v); chk("R7 clear", v, 8'h00);

        // R7 set wins over same-cycle clear
        settle(4'hF);
        wr(2'd2, 8'h0F);
        pin_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd2, v); chk("R7 set beats clear", v, 8'h01);

        // R10 sense change suppresses edge in that cycle
        settle(4'hF);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h0F);
        pin_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = 8'h03; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(2'd2, v); chk("R10 suppressed edge", v, 8'h00);
        chk("R10 no request", irq_vec, 4'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule